// File: doc/BRIEF.md
# Probabilistic Replication Writeback Selector

This block sits beside one private L2 bank of a chip multiprocessor. Each L1 writeback of a shared read-only line reaches it with the line address and the current replication level. For each one, the block decides between two destinations:

- the local L2 bank, which creates a replica;
- the next bank on a one-way ring of private L2 banks, which creates no replica.

A writeback that travels the ring merges with any existing copy it meets. This is why refusing a replica costs no capacity. Evictions in L2 never force evictions in L1.

The decision is random, with a probability set by the 3-bit level: never, 1/64, 1/16, 1/4, 1/2 or always. The random sample comes from an internal 16-bit LFSR that steps once per writeback. Lines written back often therefore tend to end up replicated. The block also emits a pulse and keeps a saturating count of local replications, which outside adaptation logic uses to move the level.

Top module: `repl_wb_select`

## Requirements
- R1: While rst_ni is low, local_wr_o, ring_fwd_o and repl_pulse_o are 0, repl_count_o is 0, and the LFSR holds 16'hACE1.
- R2: The LFSR is a 16-bit Fibonacci register. It shifts left, and the XOR of bits 15, 13, 12 and 10 enters at bit 0. It steps once per cycle with wb_valid_i high and never otherwise. The decision uses the low 6 bits of the state held before the step.
- R3: In the cycle after a cycle with wb_valid_i high, exactly one of local_wr_o and ring_fwd_o is 1. In the cycle after a cycle with wb_valid_i low, both are 0.
- R4: Level 0 never replicates. Every writeback at level 0 gives ring_fwd_o.
- R5: Level 5 always replicates, and levels 6 and 7 act as level 5.
- R6: Levels 1, 2, 3 and 4 replicate when the 6-bit sample is below 1, 4, 16 and 32 respectively.
- R7: wb_addr_o carries the address of the writeback decided in the previous cycle.
- R8: ring_dest_o is (node_id_i + 1) mod 8, taken from the writeback's cycle. Node 7 wraps to 0.
- R9: Each replication raises repl_pulse_o in the same cycle as local_wr_o and adds 1 to repl_count_o at that same edge.
- R10: repl_count_o saturates at 65535 and stays there on further replications. repl_pulse_o still fires on each replication.
- R11: Writebacks on back-to-back cycles are each decided with a fresh sample. Idle cycles leave the sample sequence unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wb_valid_i | input | 1 | Writeback present this cycle |
| wb_addr_i | input | 32 | Line address of the writeback |
| repl_level_i | input | 3 | Replication level 0..5 (6, 7 act as 5) |
| node_id_i | input | 3 | This bank's ring position |
| local_wr_o | output | 1 | Write line into the local L2 (replica) |
| ring_fwd_o | output | 1 | Forward line to the next ring bank |
| wb_addr_o | output | 32 | Address of the decided writeback |
| ring_dest_o | output | 3 | Ring position of the next bank |
| repl_pulse_o | output | 1 | One pulse per replication |
| repl_count_o | output | 16 | Saturating replication count |

## Verification
The assertions assume that reset is asserted before the first edge and that node_id_i is a valid ring position below 8. They place no limit on levels 6 and 7, and no gap is required between writebacks. The bench drives every node identity from 0 to 7 and all eight level codes. It mixes back-to-back writebacks with idle gaps of several cycles, and it begins each phase from reset. It predicts every decision with its own model of the 16-bit sample register.

// File: rtl/repl_sel_pkg.sv
package repl_sel_pkg;
  localparam int unsigned LFSR_W    = 16;
  localparam int unsigned SAMPLE_W  = 6;
  localparam int unsigned LEVEL_W   = 3;
  localparam int unsigned MAX_LEVEL = 5;

  // log2 of the inverse probability per level: 6,4,2,1,0 for 1/64..1
  function automatic int unsigned inv_prob_log2(input logic [LEVEL_W-1:0] lvl);
    case (lvl)
      3'd1:    return 6;
      3'd2:    return 4;
      3'd3:    return 2;
      3'd4:    return 1;
      default: return 0;
    endcase
  endfunction

  // Sample must be strictly below the threshold to replicate
  function automatic logic [SAMPLE_W:0] level_threshold(input logic [LEVEL_W-1:0] lvl);
    logic [SAMPLE_W:0] thr;
    if (lvl == '0) thr = '0;
    else thr = (SAMPLE_W+1)'(1) << (SAMPLE_W - inv_prob_log2(lvl));
    return thr;
  endfunction
endpackage

// File: rtl/repl_lfsr.sv
module repl_lfsr #(
  parameter int unsigned WIDTH = 16,
  parameter logic [WIDTH-1:0] TAPS = 16'hB400,
  parameter logic [WIDTH-1:0] SEED = 16'hACE1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  output logic [WIDTH-1:0] state_o
);
  logic [WIDTH-1:0] state_q;
  logic [WIDTH-1:0] tap_bits;
  logic             fb;

  for (genvar i = 0; i < WIDTH; i++) begin : g_tap
    assign tap_bits[i] = TAPS[i] & state_q[i];
  end
  assign fb = ^tap_bits;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    state_q <= SEED;
    else if (adv_i) state_q <= {state_q[WIDTH-2:0], fb};
  end

  assign state_o = state_q;
endmodule

// File: rtl/repl_decide.sv
module repl_decide
  import repl_sel_pkg::*;
(
  input  logic [LEVEL_W-1:0]  level_i,
  input  logic [SAMPLE_W-1:0] sample_i,
  output logic                grant_o
);
  logic [SAMPLE_W:0] thr;

  always_comb begin
    thr     = level_threshold(level_i);
    grant_o = ({1'b0, sample_i} < thr);
  end
endmodule

// File: rtl/repl_count.sv
module repl_count #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  output logic             pulse_o,
  output logic [CNT_W-1:0] count_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;
  logic             pulse_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= inc_i;
      if (inc_i && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign pulse_o = pulse_q;
  assign count_o = cnt_q;
endmodule

// File: rtl/repl_wb_select.sv
module repl_wb_select
  import repl_sel_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned NODES  = 8,
  parameter int unsigned CNT_W  = 16,
  parameter logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1,
  localparam int unsigned NODE_W = $clog2(NODES)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wb_valid_i,
  input  logic [ADDR_W-1:0]  wb_addr_i,
  input  logic [LEVEL_W-1:0] repl_level_i,
  input  logic [NODE_W-1:0]  node_id_i,
  output logic               local_wr_o,
  output logic               ring_fwd_o,
  output logic [ADDR_W-1:0]  wb_addr_o,
  output logic [NODE_W-1:0]  ring_dest_o,
  output logic               repl_pulse_o,
  output logic [CNT_W-1:0]   repl_count_o
);
  logic [LFSR_W-1:0] lfsr_state;
  logic              grant;
  logic              do_local;
  logic [NODE_W-1:0] next_node;

  logic              local_q, ring_q;
  logic [ADDR_W-1:0] addr_q;
  logic [NODE_W-1:0] dest_q;

  repl_lfsr #(.WIDTH(LFSR_W), .TAPS(16'hB400), .SEED(LFSR_SEED)) u_lfsr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .adv_i   (wb_valid_i),
    .state_o (lfsr_state)
  );

  repl_decide u_decide (
    .level_i  (repl_level_i),
    .sample_i (lfsr_state[SAMPLE_W-1:0]),
    .grant_o  (grant)
  );

  assign do_local  = wb_valid_i & grant;
  assign next_node = (node_id_i == NODE_W'(NODES-1)) ? '0 : node_id_i + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      local_q <= 1'b0;
      ring_q  <= 1'b0;
      addr_q  <= '0;
      dest_q  <= '0;
    end else begin
      local_q <= do_local;
      ring_q  <= wb_valid_i & ~grant;
      if (wb_valid_i) begin
        addr_q <= wb_addr_i;
        dest_q <= next_node;
      end
    end
  end

  repl_count #(.CNT_W(CNT_W)) u_count (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .inc_i   (do_local),
    .pulse_o (repl_pulse_o),
    .count_o (repl_count_o)
  );

  assign local_wr_o  = local_q;
  assign ring_fwd_o  = ring_q;
  assign wb_addr_o   = addr_q;
  assign ring_dest_o = dest_q;
endmodule

// File: rtl/repl_wb_select_chk.sv
module repl_wb_select_chk #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned NODES  = 8,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned NODE_W = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wb_valid_i,
  input logic [ADDR_W-1:0] wb_addr_i,
  input logic [2:0]        repl_level_i,
  input logic [NODE_W-1:0] node_id_i,
  input logic              local_wr_o,
  input logic              ring_fwd_o,
  input logic [ADDR_W-1:0] wb_addr_o,
  input logic [NODE_W-1:0] ring_dest_o,
  input logic              repl_pulse_o,
  input logic [CNT_W-1:0]  repl_count_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  a_r3_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({local_wr_o, ring_fwd_o}));

  a_r3_one_after_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_valid_i |=> (local_wr_o ^ ring_fwd_o));

  a_r3_none_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wb_valid_i |=> !(local_wr_o || ring_fwd_o));

  a_r4_level0_ring: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wb_valid_i && repl_level_i == 3'd0) |=> ring_fwd_o);

  a_r5_top_local: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wb_valid_i && repl_level_i >= 3'd5) |=> local_wr_o);

  a_r7_addr_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_valid_i |=> (wb_addr_o == $past(wb_addr_i)));

  a_r8_ring_next: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_valid_i |=> (ring_dest_o ==
      (($past(node_id_i) == NODE_W'(NODES-1)) ? '0 : $past(node_id_i) + 1'b1)));

  a_r9_pulse_with_local: assert property (@(posedge clk_i) disable iff (!rst_ni)
    repl_pulse_o == local_wr_o);

  a_r9_count_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (repl_count_o != CNT_MAX) |=>
      (repl_count_o == $past(repl_count_o) + CNT_W'(local_wr_o)));

  a_r10_saturate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (repl_count_o == CNT_MAX) |=> (repl_count_o == CNT_MAX));
endmodule

bind repl_wb_select repl_wb_select_chk #(
  .ADDR_W(ADDR_W), .NODES(NODES), .CNT_W(CNT_W), .NODE_W(NODE_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .wb_valid_i   (wb_valid_i),
  .wb_addr_i    (wb_addr_i),
  .repl_level_i (repl_level_i),
  .node_id_i    (node_id_i),
  .local_wr_o   (local_wr_o),
  .ring_fwd_o   (ring_fwd_o),
  .wb_addr_o    (wb_addr_o),
  .ring_dest_o  (ring_dest_o),
  .repl_pulse_o (repl_pulse_o),
  .repl_count_o (repl_count_o)
);

// File: tb/tb_repl_wb_select.sv
`timescale 1ns/1ps
module tb_repl_wb_select;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wb_valid_i = 1'b0;
  logic [31:0] wb_addr_i = '0;
  logic [2:0]  repl_level_i = '0;
  logic [2:0]  node_id_i = '0;
  logic        local_wr_o, ring_fwd_o, repl_pulse_o;
  logic [31:0] wb_addr_o;
  logic [2:0]  ring_dest_o;
  logic [15:0] repl_count_o;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [15:0] m_lfsr = 16'hACE1;
  logic [15:0] m_cnt  = '0;

  always #5 clk_i = ~clk_i;

  repl_wb_select dut (.*);

  // {level, addr, node, idle gap}
  localparam logic [41:0] VEC [12] = '{
    {3'd5, 32'h0000_1000, 3'd0, 4'd0},
    {3'd0, 32'h0000_1040, 3'd1, 4'd0},
    {3'd4, 32'h0000_1080, 3'd2, 4'd2},
    {3'd3, 32'hDEAD_BEC0, 3'd3, 4'd0},
    {3'd2, 32'h1234_5640, 3'd4, 4'd3},
    {3'd1, 32'hFFFF_FFC0, 3'd5, 4'd0},
    {3'd6, 32'h0BAD_F000, 3'd6, 4'd1},
    {3'd7, 32'hCAFE_0040, 3'd7, 4'd0},
    {3'd0, 32'h0000_0000, 3'd7, 4'd0},
    {3'd4, 32'h8000_0000, 3'd0, 4'd5},
    {3'd3, 32'h5555_5540, 3'd2, 4'd0},
    {3'd5, 32'hAAAA_AA80, 3'd6, 4'd1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic exp_grant(input logic [2:0] lvl, input logic [5:0] s);
    case (lvl)
      3'd0: return 1'b0;
      3'd1: return s == 6'd0;
      3'd2: return s < 6'd4;
      3'd3: return s < 6'd16;
      3'd4: return s < 6'd32;
      default: return 1'b1;
    endcase
  endfunction

  // Called at a negedge; returns at the next negedge with valid low
  task automatic do_wb(input logic [2:0] lvl, input logic [31:0] addr,
                       input logic [2:0] id, input bit check);
    logic g;
    g = exp_grant(lvl, m_lfsr[5:0]);
    m_lfsr = {m_lfsr[14:0], m_lfsr[15] ^ m_lfsr[13] ^ m_lfsr[12] ^ m_lfsr[10]};
    if (g && m_cnt != 16'hFFFF) m_cnt = m_cnt + 1'b1;
    wb_valid_i = 1'b1; wb_addr_i = addr; repl_level_i = lvl; node_id_i = id;
    @(negedge clk_i);
    wb_valid_i = 1'b0;
    if (check) begin
      chk("R6 local_wr", 32'(local_wr_o), 32'(g));
      chk("R3 ring_fwd", 32'(ring_fwd_o), 32'(!g));
      chk("R7 addr", wb_addr_o, addr);
      chk("R8 dest", 32'(ring_dest_o), 32'((id + 4'd1) % 4'd8));
      chk("R9 pulse", 32'(repl_pulse_o), 32'(g));
      chk("R9 count", 32'(repl_count_o), 32'(m_cnt));
    end
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk_i);
      chk("R3 idle no strobe", 32'({local_wr_o, ring_fwd_o}), 32'd0);
    end
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    #1;
    chk("R1 reset local", 32'(local_wr_o), 32'd0);
    chk("R1 reset ring", 32'(ring_fwd_o), 32'd0);
    chk("R1 reset pulse", 32'(repl_pulse_o), 32'd0);
    chk("R1 reset count", 32'(repl_count_o), 32'd0);
    m_lfsr = 16'hACE1; m_cnt = '0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    do_reset();
    // Table walk: R2 R4 R5 R11 via decisions and gaps
    for (int i = 0; i < 12; i++) begin
      do_wb(VEC[i][41:39], VEC[i][38:7], VEC[i][6:4], 1'b1);
      idle(int'(VEC[i][3:0]));
    end
    // R4 level 0 always ring
    for (int i = 0; i < 20; i++) do_wb(3'd0, 32'(i * 64), 3'(i), 1'b1);
    // R6 R2 R11 probabilistic levels, back to back
    for (int i = 0; i < 400; i++) do_wb(3'd1 + 3'(i % 4), 32'h4000_0000 + 32'(i), 3'(i), 1'b1);
    // R8 wrap from node 7
    do_wb(3'd0, 32'h0000_7700, 3'd7, 1'b1);
    chk("R8 wrap dest", 32'(ring_dest_o), 32'd0);
    // R1 async reset mid-run restarts sequence
    do_reset();
    do_wb(3'd4, 32'h0000_0C00, 3'd3, 1'b1);
    // R10 saturation at level 5
    do_reset();
    for (int i = 0; i < 65540; i++) do_wb(3'd5, 32'(i), 3'd1, 1'b0);
    chk("R10 saturated count", 32'(repl_count_o), 32'hFFFF);
    do_wb(3'd5, 32'h0000_ABC0, 3'd2, 1'b1);
    chk("R10 pulse at saturation", 32'(repl_pulse_o), 32'd1);
    chk("R10 held", 32'(repl_count_o), 32'hFFFF);
    idle(2);
    done = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule